// File: doc/BRIEF.md
# I2C Port-Expander Register Target

This block is an I2C target that presents a 16-bit general-purpose I/O expander, split into two 8-bit ports (port A drives bits 7:0 of every pin vector, port B bits 15:8). A bus controller addresses it with a 7-bit device address and writes a register pointer. It then moves one or more data bytes into or out of a small register file. That file holds, per port, a direction byte, a pull-up byte, a port byte and an output latch byte, plus one configuration byte. The register contents drive the pin output-enable, output-value and pull-up vectors, and a pin input vector is sampled every clock so that reads return live levels.

SCL and SDA are oversampled by the system clock through a synchronizer. SDA is open-drain: the block sees the bus level on an input and pulls the line low through a drive-low enable. A write is start, address with R/W=0, pointer, data bytes, stop. A read is start, address with R/W=0, pointer, repeated start, address with R/W=1, data bytes, stop. The pointer steps after each data byte unless a configuration bit freezes it.

Top module: `i2c_gpio_expander`

## Requirements
- R1: The block acknowledges an address byte whose upper four bits are 0100 and whose next three bits equal `strap_i`. For any other address it neither acknowledges nor drives SDA, and it ignores the bytes that follow until the next start.
- R2: Bit 0 of the address byte selects the direction: 0 for a write by the controller, 1 for a read in which the block shifts register data out MSB first.
- R3: In a write transfer, the first byte after the address loads the register pointer. Each later byte is written to the register the pointer selects.
- R4: The register map is: direction A/B at 0x00/0x01, configuration at 0x0A (mirrored at 0x0B), pull-up A/B at 0x0C/0x0D, port A/B at 0x12/0x13, latch A/B at 0x14/0x15. Reset values are 0xFF for direction, 0x00 for pull-ups, latches and configuration.
- R5: A direction bit of 1 makes the pin an input, so `pin_oe_o` is the inverse of the direction byte. `pin_pullup_o` equals the pull-up bytes.
- R6: Writing a port register updates the matching latch. Reading a port register returns the sampled `pin_in_i` bits. Reading a latch returns its contents. `pin_out_o` equals the latches.
- R7: With configuration bit 5 at 0, the pointer advances by one after each written byte and after each read byte the controller acknowledges. With bit 5 at 1, the pointer stays fixed.
- R8: While advancing, the pointer moves from 0x15 to 0x00.
- R9: In the configuration byte only bits 7 and 5 hold state; all other bits read 0.
- R10: Addresses outside the map read 0x00, and writes to them change nothing.
- R11: The block acknowledges every byte written to it. During a read, a NACK from the controller leaves SDA released until the next start.
- R12: A stop releases SDA and returns the block to idle, even in the middle of a byte. A start or repeated start restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Low three bits of the device address |
| pin_in_i | input | 16 | Pin levels, port A in 7:0 and port B in 15:8 |
| pin_oe_o | output | 16 | 1 where a pin is driven as an output |
| pin_out_o | output | 16 | Output-latch value per pin |
| pin_pullup_o | output | 16 | 1 where the pin pull-up is enabled |

## Verification
The bench targets the port-register asymmetry. A design that read back the latch from 0x12/0x13, or wrote the pins' register, would return the wrong byte after the pins and the latch are given different values. It checks the pointer at its edges: a read from 0x15 must continue at 0x00, and with the freeze bit set a two-byte write must land twice on one register; an off-by-one or a missing wrap shows up as data from the wrong neighbour. It sends a foreign address followed by data and a stop in mid-byte, which a design that kept decoding or committed partial bytes would turn into a latch change. It also checks the mirrored configuration address, the unimplemented bits and the unmapped holes, where a loose decoder returns stale data.

// File: rtl/xpx_pkg.sv
package xpx_pkg;
   localparam int PTR_W = 8;

   localparam logic [PTR_W-1:0] RA_DIR  = 8'h00;
   localparam logic [PTR_W-1:0] RA_CFG0 = 8'h0A;
   localparam logic [PTR_W-1:0] RA_CFG1 = 8'h0B;
   localparam logic [PTR_W-1:0] RA_PU   = 8'h0C;
   localparam logic [PTR_W-1:0] RA_PORT = 8'h12;
   localparam logic [PTR_W-1:0] RA_LAT  = 8'h14;
   localparam logic [PTR_W-1:0] RA_LAST = 8'h15;

   localparam int CFG_BANK_BIT = 7;
   localparam int CFG_SEQ_BIT  = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_ADDR,
      ST_WDATA,
      ST_ACK_WR,
      ST_TX,
      ST_MACK
   } eng_state_t;
endpackage

// File: rtl/xpx_bus_sync.sv
module xpx_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_p, sda_p;
   logic              scl_s;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  scl_chain[0] <= 1'b1;
                  sda_chain[0] <= 1'b1;
               end else begin
                  scl_chain[0] <= scl_i;
                  sda_chain[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  scl_chain[g] <= 1'b1;
                  sda_chain[g] <= 1'b1;
               end else begin
                  scl_chain[g] <= scl_chain[g-1];
                  sda_chain[g] <= sda_chain[g-1];
               end
            end
         end
      end
   endgenerate

   assign scl_s = scl_chain[STAGES-1];
   assign sda_s = sda_chain[STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_p;
   assign scl_fall  = ~scl_s &  scl_p;
   assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
   assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;
endmodule

// File: rtl/xpx_byte_engine.sv
module xpx_byte_engine
   import xpx_pkg::*;
#(
   parameter int          STRAP_W = 3,
   parameter int          HI_W    = 4,
   parameter logic [HI_W-1:0] DEV_HI = 4'b0100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   input  logic [STRAP_W-1:0] strap,
   input  logic [7:0]         rd_data,
   output logic               ptr_load,
   output logic               wr_en,
   output logic               rd_adv,
   output logic [7:0]         wr_data,
   output logic               sda_drive_low
);
   eng_state_t  state;
   logic [7:0]  sh;
   logic [7:0]  tx;
   logic [2:0]  bitcnt;
   logic        byte_done;
   logic        first;
   logic        rw;
   logic        nack;
   logic        addr_hit;

   assign addr_hit = (sh[7:1] == {DEV_HI, strap});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         sh            <= '0;
         tx            <= '0;
         bitcnt        <= '0;
         byte_done     <= 1'b0;
         first         <= 1'b0;
         rw            <= 1'b0;
         nack          <= 1'b0;
         sda_drive_low <= 1'b0;
         ptr_load      <= 1'b0;
         wr_en         <= 1'b0;
         rd_adv        <= 1'b0;
         wr_data       <= '0;
      end else begin
         ptr_load <= 1'b0;
         wr_en    <= 1'b0;
         rd_adv   <= 1'b0;
         if (stop_det) begin
            state         <= ST_IDLE;
            sda_drive_low <= 1'b0;
            byte_done     <= 1'b0;
         end else if (start_det) begin
            state         <= ST_ADDR;
            sda_drive_low <= 1'b0;
            bitcnt        <= '0;
            byte_done     <= 1'b0;
            first         <= 1'b1;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_ADDR, ST_WDATA: begin
                  if (scl_rise) begin
                     sh     <= {sh[6:0], sda_s};
                     bitcnt <= bitcnt + 3'd1;
                     if (bitcnt == 3'd7) byte_done <= 1'b1;
                  end else if (scl_fall && byte_done) begin
                     byte_done <= 1'b0;
                     if (state == ST_ADDR) begin
                        if (addr_hit) begin
                           sda_drive_low <= 1'b1;
                           rw            <= sh[0];
                           state         <= ST_ACK_ADDR;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        sda_drive_low <= 1'b1;
                        state         <= ST_ACK_WR;
                        wr_data       <= sh;
                        ptr_load      <= first;
                        wr_en         <= ~first;
                        first         <= 1'b0;
                     end
                  end
               end
               ST_ACK_ADDR: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (!rw) begin
                        sda_drive_low <= 1'b0;
                        state         <= ST_WDATA;
                     end else begin
                        tx            <= rd_data;
                        sda_drive_low <= ~rd_data[7];
                        state         <= ST_TX;
                     end
                  end
               end
               ST_ACK_WR: begin
                  if (scl_fall) begin
                     sda_drive_low <= 1'b0;
                     bitcnt        <= '0;
                     state         <= ST_WDATA;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     bitcnt <= bitcnt + 3'd1;
                     if (bitcnt == 3'd7) begin
                        sda_drive_low <= 1'b0;
                        state         <= ST_MACK;
                     end else begin
                        sda_drive_low <= ~tx[6];
                        tx            <= {tx[6:0], 1'b0};
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     nack   <= sda_s;
                     rd_adv <= ~sda_s;
                  end else if (scl_fall) begin
                     if (nack) begin
                        state <= ST_IDLE;
                     end else begin
                        tx            <= rd_data;
                        sda_drive_low <= ~rd_data[7];
                        bitcnt        <= '0;
                        state         <= ST_TX;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/xpx_regfile.sv
module xpx_regfile
   import xpx_pkg::*;
#(
   parameter int PORT_W    = 8,
   parameter int NUM_PORTS = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              ptr_load,
   input  logic                              wr_en,
   input  logic                              rd_adv,
   input  logic [7:0]                        wr_data,
   input  logic [NUM_PORTS*PORT_W-1:0]       pin_in,
   output logic [7:0]                        rd_data,
   output logic [NUM_PORTS*PORT_W-1:0]       dir_o,
   output logic [NUM_PORTS*PORT_W-1:0]       pu_o,
   output logic [NUM_PORTS*PORT_W-1:0]       lat_o,
   output logic [PTR_W-1:0]                  ptr_o,
   output logic                              step_o,
   output logic                              seq_hold_o
);
   localparam int VEC_W = NUM_PORTS * PORT_W;

   logic [PTR_W-1:0] ptr;
   logic [VEC_W-1:0] pin_q;
   logic             cfg_bank;
   logic             cfg_seq;
   logic             step;
   logic             cfg_hit;

   assign step    = wr_en | rd_adv;
   assign cfg_hit = (ptr == RA_CFG0) || (ptr == RA_CFG1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr      <= '0;
         pin_q    <= '0;
         cfg_bank <= 1'b0;
         cfg_seq  <= 1'b0;
      end else begin
         pin_q <= pin_in;
         if (wr_en && cfg_hit) begin
            cfg_bank <= wr_data[CFG_BANK_BIT];
            cfg_seq  <= wr_data[CFG_SEQ_BIT];
         end
         if (ptr_load) begin
            ptr <= wr_data;
         end else if (step && !cfg_seq) begin
            ptr <= (ptr == RA_LAST) ? '0 : ptr + 1'b1;
         end
      end
   end

   genvar p;
   generate
      for (p = 0; p < NUM_PORTS; p++) begin : g_port
         logic hit_dir, hit_pu, hit_lat;
         assign hit_dir = (ptr == RA_DIR  + PTR_W'(p));
         assign hit_pu  = (ptr == RA_PU   + PTR_W'(p));
         assign hit_lat = (ptr == RA_PORT + PTR_W'(p)) ||
                          (ptr == RA_LAT  + PTR_W'(p));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dir_o[p*PORT_W +: PORT_W] <= '1;
               pu_o [p*PORT_W +: PORT_W] <= '0;
               lat_o[p*PORT_W +: PORT_W] <= '0;
            end else if (wr_en) begin
               if (hit_dir) dir_o[p*PORT_W +: PORT_W] <= wr_data;
               if (hit_pu)  pu_o [p*PORT_W +: PORT_W] <= wr_data;
               if (hit_lat) lat_o[p*PORT_W +: PORT_W] <= wr_data;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (cfg_hit) begin
         rd_data[CFG_BANK_BIT] = cfg_bank;
         rd_data[CFG_SEQ_BIT]  = cfg_seq;
      end
      for (int i = 0; i < NUM_PORTS; i++) begin
         if (ptr == RA_DIR  + PTR_W'(i)) rd_data = dir_o[i*PORT_W +: PORT_W];
         if (ptr == RA_PU   + PTR_W'(i)) rd_data = pu_o [i*PORT_W +: PORT_W];
         if (ptr == RA_PORT + PTR_W'(i)) rd_data = pin_q[i*PORT_W +: PORT_W];
         if (ptr == RA_LAT  + PTR_W'(i)) rd_data = lat_o[i*PORT_W +: PORT_W];
      end
   end

   assign ptr_o      = ptr;
   assign step_o     = step;
   assign seq_hold_o = cfg_seq;
endmodule

// File: rtl/i2c_gpio_expander.sv
module i2c_gpio_expander
   import xpx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PORT_W      = 8,
   parameter int NUM_PORTS   = 2,
   parameter int STRAP_W     = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          scl_i,
   input  logic                          sda_i,
   output logic                          sda_drive_low_o,
   input  logic [STRAP_W-1:0]            strap_i,
   input  logic [NUM_PORTS*PORT_W-1:0]   pin_in_i,
   output logic [NUM_PORTS*PORT_W-1:0]   pin_oe_o,
   output logic [NUM_PORTS*PORT_W-1:0]   pin_out_o,
   output logic [NUM_PORTS*PORT_W-1:0]   pin_pullup_o
);
   localparam int VEC_W = NUM_PORTS * PORT_W;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PORT_W != 8) begin : g_bad_width
         $error("PORT_W must be 8 to match the byte-wide map");
      end
      if (NUM_PORTS != 2) begin : g_bad_ports
         $error("NUM_PORTS must be 2 for this register map");
      end
      if (STRAP_W != 3) begin : g_bad_strap
         $error("STRAP_W must be 3 for a 7-bit address");
      end
   endgenerate

   logic             sda_s_w, scl_rise_w, scl_fall_w, start_w, stop_w;
   logic             ptr_load_w, wr_en_w, rd_adv_w;
   logic [7:0]       wr_data_w, rd_data_w;
   logic [VEC_W-1:0] dir_w;
   logic [PTR_W-1:0] ptr_w;
   logic             step_w, seq_w;

   xpx_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s_w),
      .scl_rise  (scl_rise_w),
      .scl_fall  (scl_fall_w),
      .start_det (start_w),
      .stop_det  (stop_w)
   );

   xpx_byte_engine #(.STRAP_W(STRAP_W)) u_eng (
      .clk           (clk),
      .rst_n         (rst_n),
      .sda_s         (sda_s_w),
      .scl_rise      (scl_rise_w),
      .scl_fall      (scl_fall_w),
      .start_det     (start_w),
      .stop_det      (stop_w),
      .strap         (strap_i),
      .rd_data       (rd_data_w),
      .ptr_load      (ptr_load_w),
      .wr_en         (wr_en_w),
      .rd_adv        (rd_adv_w),
      .wr_data       (wr_data_w),
      .sda_drive_low (sda_drive_low_o)
   );

   xpx_regfile #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .ptr_load   (ptr_load_w),
      .wr_en      (wr_en_w),
      .rd_adv     (rd_adv_w),
      .wr_data    (wr_data_w),
      .pin_in     (pin_in_i),
      .rd_data    (rd_data_w),
      .dir_o      (dir_w),
      .pu_o       (pin_pullup_o),
      .lat_o      (pin_out_o),
      .ptr_o      (ptr_w),
      .step_o     (step_w),
      .seq_hold_o (seq_w)
   );

   assign pin_oe_o = ~dir_w;
endmodule

// File: rtl/xpx_checker.sv
module xpx_checker
   import xpx_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             drive_low,
   input logic             scl_fall,
   input logic             start_det,
   input logic             stop_det,
   input logic             step,
   input logic             seq_hold,
   input logic [PTR_W-1:0] ptr
);
   // R12: a stop releases the data line on the next cycle
   a_r12_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !drive_low);

   // R11: the data line changes only after a clock fall or a bus condition
   a_r11_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_low != $past(drive_low)) |-> $past(scl_fall || start_det || stop_det));

   // R8: pointer wraps from the last mapped address to zero
   a_r8_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !seq_hold && ptr == RA_LAST) |=> (ptr == '0));

   // R7: pointer advances by one while sequential mode is on
   a_r7_ptr_incr: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !seq_hold && ptr != RA_LAST) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

   // R7: pointer holds while the freeze bit is set
   a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (step && seq_hold) |=> $stable(ptr));
endmodule

bind i2c_gpio_expander xpx_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .drive_low (sda_drive_low_o),
   .scl_fall  (scl_fall_w),
   .start_det (start_w),
   .stop_det  (stop_w),
   .step      (step_w),
   .seq_hold  (seq_w),
   .ptr       (ptr_w)
);

// File: tb/sim_i2c_gpio_expander.sv
module sim_i2c_gpio_expander;
   localparam int Q = 5;
   localparam int H = 10;
   localparam logic [2:0] STRAP = 3'b101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_line;
   logic        drv;
   logic [15:0] pin_in = 16'hBEEF;
   logic [15:0] oe, pout, pu;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~drv;

   i2c_gpio_expander u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl_m),
      .sda_i           (sda_line),
      .sda_drive_low_o (drv),
      .strap_i         (STRAP),
      .pin_in_i        (pin_in),
      .pin_oe_o        (oe),
      .pin_out_o       (pout),
      .pin_pullup_o    (pu)
   );

   // {write pointer, write data, read pointer, expected read}
   localparam logic [31:0] VEC [10] = '{
      {8'h00, 8'h5A, 8'h00, 8'h5A},   // R4 direction A
      {8'h01, 8'hC3, 8'h01, 8'hC3},   // R4 direction B
      {8'h0C, 8'h0F, 8'h0C, 8'h0F},   // R4 pull-up A
      {8'h0D, 8'hF0, 8'h0D, 8'hF0},   // R4 pull-up B
      {8'h14, 8'h81, 8'h14, 8'h81},   // R6 latch A
      {8'h15, 8'h7E, 8'h15, 8'h7E},   // R6 latch B
      {8'h0A, 8'hFF, 8'h0B, 8'hA0},   // R9 mirror, bits 7 and 5 only
      {8'h0B, 8'h00, 8'h0A, 8'h00},   // R9 clear via mirror
      {8'h03, 8'h55, 8'h03, 8'h00},   // R10 unmapped
      {8'h12, 8'h33, 8'h14, 8'h33}    // R6 port write lands in latch
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic wbit(input logic b);
      sda_m = b; tick(Q); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(Q);
   endtask

   task automatic rbit(output logic b);
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic wbyte(input logic [7:0] d, output logic ack);
      for (int i = 7; i >= 0; i--) wbit(d[i]);
      rbit(ack);
   endtask

   task automatic rbyte(input logic last, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         rbit(b);
         d[i] = b;
      end
      wbit(last);
   endtask

   task automatic reg_write(input logic [7:0] ptr, input int n,
                            input logic [7:0] d0, input logic [7:0] d1);
      logic a;
      bus_start();
      wbyte({4'b0100, STRAP, 1'b0}, a); chk("R1 address ack", 16'(a), 16'h0);
      wbyte(ptr, a);                    chk("R11 pointer ack", 16'(a), 16'h0);
      wbyte(d0, a);                     chk("R11 data ack", 16'(a), 16'h0);
      if (n > 1) begin
         wbyte(d1, a);                  chk("R11 second data ack", 16'(a), 16'h0);
      end
      bus_stop();
   endtask

   task automatic reg_read(input logic [7:0] ptr, input int n,
                           output logic [7:0] d0, output logic [7:0] d1);
      logic a;
      d1 = 8'h00;
      bus_start();
      wbyte({4'b0100, STRAP, 1'b0}, a);
      wbyte(ptr, a);
      bus_start();
      wbyte({4'b0100, STRAP, 1'b1}, a); chk("R2 read address ack", 16'(a), 16'h0);
      rbyte(n == 1, d0);
      if (n > 1) rbyte(1'b1, d1);
      tick(2);
      chk("R11 released after NACK", 16'(drv), 16'h0);
      bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got hang expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] r0, r1;
      logic       a;
      tick(4);
      rst_n = 1'b1;
      tick(4);

      // reset state
      chk("R4 reset oe", oe, 16'h0000);
      chk("R4 reset pull-up", pu, 16'h0000);
      chk("R4 reset latch", pout, 16'h0000);
      chk("R12 reset SDA released", 16'(drv), 16'h0);
      reg_read(8'h00, 1, r0, r1); chk("R4 reset direction A", 16'(r0), 16'h00FF);
      reg_read(8'h0A, 1, r0, r1); chk("R9 reset config", 16'(r0), 16'h0000);

      // table walk
      foreach (VEC[i]) begin
         reg_write(VEC[i][31:24], 1, VEC[i][23:16], 8'h00);
         reg_read(VEC[i][15:8], 1, r0, r1);
         chk($sformatf("R3 vector %0d", i), 16'(r0), 16'(VEC[i][7:0]));
      end

      // R1: foreign address, then data that must be ignored
      bus_start();
      wbyte({4'b0100, 3'b000, 1'b0}, a); chk("R1 foreign address NACK", 16'(a), 16'h1);
      wbyte(8'h14, a);                   chk("R1 no ack after foreign address", 16'(a), 16'h1);
      wbyte(8'hFF, a);
      bus_stop();
      chk("R1 latch untouched", pout, 16'h7E33);

      // R5: direction and pull-up drive the pin controls
      reg_write(8'h00, 1, 8'h0F, 8'h00);
      chk("R5 oe port A", 16'(oe[7:0]), 16'h00F0);
      reg_write(8'h0D, 1, 8'h3C, 8'h00);
      chk("R5 pull-up port B", 16'(pu[15:8]), 16'h003C);

      // R3 / R7: sequential write across both latches
      reg_write(8'h14, 2, 8'h11, 8'h22);
      chk("R7 sequential write latches", pout, 16'h2211);

      // R12: stop in the middle of a byte commits nothing
      bus_start();
      wbyte({4'b0100, STRAP, 1'b0}, a);
      wbyte(8'h14, a);
      wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b0);
      bus_stop();
      chk("R12 mid-byte stop", pout, 16'h2211);

      // R6: port reads return pins, port writes go to the latch
      pin_in = 16'hBEEF;
      reg_read(8'h12, 2, r0, r1);
      chk("R6 port A reads pins", 16'(r0), 16'h00EF);
      chk("R6 port B reads pins", 16'(r1), 16'h00BE);
      reg_write(8'h13, 1, 8'h99, 8'h00);
      chk("R6 port write to latch B", 16'(pout[15:8]), 16'h0099);
      reg_read(8'h13, 1, r0, r1);
      chk("R6 port B still pins", 16'(r0), 16'h00BE);

      // R8: wrap from 0x15 to 0x00
      reg_read(8'h15, 2, r0, r1);
      chk("R8 last register", 16'(r0), 16'h0099);
      chk("R8 wrapped to direction A", 16'(r1), 16'h000F);

      // R7: freeze bit holds the pointer
      reg_write(8'h0A, 1, 8'h20, 8'h00);
      reg_read(8'h14, 2, r0, r1);
      chk("R7 frozen read first", 16'(r0), 16'h0011);
      chk("R7 frozen read second", 16'(r1), 16'h0011);
      reg_write(8'h0C, 2, 8'hAA, 8'h55);
      chk("R7 frozen write", pu, 16'h3C55);
      reg_write(8'h0A, 1, 8'h00, 8'h00);
      reg_read(8'h0B, 1, r0, r1);
      chk("R9 config cleared", 16'(r0), 16'h0000);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule